// File: doc/BRIEF.md
# Interrupt Source Enable and Status Gate

This block collects up to eight single-cycle event pulses into one interrupt request. A byte-wide enable mask is loaded by a write strobe. The latched status of the enabled sources can be read at any time. Only the bit positions marked in a fixed valid-source mask are ever reported; every other position reads as zero.

Software acknowledges an event by writing its enable bit to 0, which clears the latched bit. It then writes the enable back to 1 to re-arm the source. The other bits in the same write keep their enable value. A source that fires while a neighbour is being acknowledged stays latched and shows on the next read. The interrupt line is the registered OR of the latched status, so it falls one cycle after the status reads zero.

The block has no read strobe: the status output follows the latched state continuously. The event generators are outside the block.

Top module: `irq_src_gate`

## Requirements
- R1: After reset the status output is 0, the interrupt output is 0 and all enables are 0. A pulse arriving after reset with no enable write leaves the status at 0.
- R2: A pulse on an enabled source sets that status bit. The bit is visible on the status output after the clock edge that samples the pulse.
- R3: A pulse on a source whose enable is 0 before the edge is ignored. This holds even when the same cycle carries a write that sets that enable.
- R4: Status bit positions outside VALID_MASK always read 0, even when they are written to 1 and pulsed. With the default VALID_MASK of 8'hDF, this is bit 5.
- R5: A write clears every status bit whose write-data bit is 0. Status bits whose write-data bit is 1 keep their value.
- R6: After an enable is written back to 1, a later pulse on that source sets its status bit again.
- R7: Writing 8'h00 clears every status bit and disables every source.
- R8: When a pulse arrives in the same cycle as a write that clears its enable, the status bit ends up 0.
- R9: A status bit that is set stays set through cycles without a write, whether or not further pulses arrive.
- R10: The interrupt output equals the OR of the status output one clock earlier. It therefore rises and falls one cycle after the status becomes non-zero or zero.
- R11: A pulse on an enabled source in the same cycle as a write that keeps that source enabled but acknowledges another is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | N_SRC | One-cycle event pulses, one per source |
| cfg_we | input | 1 | Write strobe for the enable mask |
| cfg_wdata | input | N_SRC | New enable mask |
| status_rd | output | N_SRC | Latched status, limited to VALID_MASK |
| irq | output | 1 | Interrupt request |

## Verification
Status results are due at the first clock edge after the stimulus cycle. The interrupt line is due one edge after that, because it is registered from the status. The bench drives each stimulus at a falling edge and samples at the next falling edge. At that point the status must show the effect of the stimulus, and the interrupt must show the status of the step before. The expected interrupt values in the vector table are written one step behind the status on purpose, and the directed fall test also checks the intermediate cycle.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

   typedef enum logic [0:0] {
      IRQ_OUT_REGISTERED = 1'b0,
      IRQ_OUT_COMBINED   = 1'b1
   } irq_out_style_e;

   localparam int unsigned MAX_SRC = 32;

endpackage

// File: rtl/irq_src_enable.sv
module irq_src_enable #(
   parameter int unsigned       N_SRC      = 8,
   parameter logic [N_SRC-1:0]  VALID_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [N_SRC-1:0] wdata,
   output logic [N_SRC-1:0] en_q,
   output logic [N_SRC-1:0] kill
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (we)
         en_q <= wdata & VALID_MASK;
   end

   // a write drops the latched state of every bit written low
   always_comb kill = we ? ~wdata : '0;

endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
   parameter bit IS_VALID = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   input  logic en,
   input  logic kill,
   output logic st_q
);

   generate
      if (IS_VALID) begin : g_live
         logic st_d;
         always_comb begin
            st_d = st_q;
            if (pulse && en)
               st_d = 1'b1;
            if (kill)
               st_d = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               st_q <= 1'b0;
            else
               st_q <= st_d;
         end
      end else begin : g_tied
         assign st_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
   parameter int unsigned                   N_SRC = 8,
   parameter irq_src_pkg::irq_out_style_e   STYLE = irq_src_pkg::IRQ_OUT_REGISTERED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] st,
   output logic             irq
);

   logic any_set;
   always_comb any_set = |st;

   generate
      if (STYLE == irq_src_pkg::IRQ_OUT_REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq <= 1'b0;
            else
               irq <= any_set;
         end
      end else begin : g_comb
         assign irq = any_set;
      end
   endgenerate

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
   parameter int unsigned                  N_SRC      = 8,
   parameter logic [N_SRC-1:0]             VALID_MASK = 8'hDF,
   parameter irq_src_pkg::irq_out_style_e  IRQ_STYLE  = irq_src_pkg::IRQ_OUT_REGISTERED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_pulse,
   input  logic             cfg_we,
   input  logic [N_SRC-1:0] cfg_wdata,
   output logic [N_SRC-1:0] status_rd,
   output logic             irq
);

   localparam int unsigned LIVE_CNT = $countones(VALID_MASK);

   generate
      if (N_SRC < 1 || N_SRC > irq_src_pkg::MAX_SRC) begin : g_bad_width
         $error("irq_src_gate: N_SRC out of range");
      end
      if (LIVE_CNT == 0) begin : g_no_valid
         $error("irq_src_gate: VALID_MASK selects no source");
      end
   endgenerate

   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] kill;
   logic [N_SRC-1:0] st_q;

   irq_src_enable #(
      .N_SRC      (N_SRC),
      .VALID_MASK (VALID_MASK)
   ) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .en_q  (en_q),
      .kill  (kill)
   );

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_bit
         irq_src_latch #(
            .IS_VALID (VALID_MASK[i])
         ) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .pulse (src_pulse[i]),
            .en    (en_q[i]),
            .kill  (kill[i]),
            .st_q  (st_q[i])
         );
      end
   endgenerate

   assign status_rd = st_q;

   irq_src_merge #(
      .N_SRC (N_SRC),
      .STYLE (IRQ_STYLE)
   ) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .st    (st_q),
      .irq   (irq)
   );

endmodule

// File: rtl/irq_src_gate_chk.sv
module irq_src_gate_chk #(
   parameter int unsigned                  N_SRC      = 8,
   parameter logic [N_SRC-1:0]             VALID_MASK = 8'hDF,
   parameter irq_src_pkg::irq_out_style_e  IRQ_STYLE  = irq_src_pkg::IRQ_OUT_REGISTERED
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_pulse,
   input logic             cfg_we,
   input logic [N_SRC-1:0] cfg_wdata,
   input logic [N_SRC-1:0] status_rd,
   input logic             irq
);

   // R5 R7 R8
   write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> ((status_rd & ~$past(cfg_wdata)) == '0));

   // R4
   invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_rd & ~VALID_MASK) == '0));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ((~status_rd & $past(status_rd)) == '0));

   // R2 R3
   set_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_rd & ~$past(status_rd) & ~$past(src_pulse)) == '0));

   generate
      if (IRQ_STYLE == irq_src_pkg::IRQ_OUT_REGISTERED) begin : g_irq_chk
         // R10
         irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq == (|$past(status_rd))));
      end
   endgenerate

endmodule

bind irq_src_gate irq_src_gate_chk #(
   .N_SRC      (N_SRC),
   .VALID_MASK (VALID_MASK),
   .IRQ_STYLE  (IRQ_STYLE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_pulse (src_pulse),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .status_rd (status_rd),
   .irq       (irq)
);

// File: tb/irq_src_gate_tb_top.sv
`timescale 1ns/1ps
module irq_src_gate_tb_top;

   localparam int NV = 17;
   // {we, wdata, pulse, exp_status, exp_irq}
   localparam logic [25:0] TBL [0:NV-1] = '{
      {1'b1, 8'hFF, 8'h00, 8'h00, 1'b0},  // 0  enable all
      {1'b0, 8'h00, 8'h01, 8'h01, 1'b0},  // 1  R2
      {1'b0, 8'h00, 8'h00, 8'h01, 1'b1},  // 2  R9 R10
      {1'b0, 8'h00, 8'h22, 8'h03, 1'b1},  // 3  R4 bit5 invalid
      {1'b1, 8'hFE, 8'h00, 8'h02, 1'b1},  // 4  R5 ack bit0
      {1'b1, 8'hFC, 8'h80, 8'h80, 1'b1},  // 5  R11
      {1'b1, 8'hFF, 8'h01, 8'h80, 1'b1},  // 6  R3 same-cycle enable
      {1'b0, 8'h00, 8'h01, 8'h81, 1'b1},  // 7  R6 re-arm
      {1'b1, 8'h7F, 8'h80, 8'h01, 1'b1},  // 8  R8 clear wins
      {1'b0, 8'h00, 8'h80, 8'h01, 1'b1},  // 9  R3 disabled
      {1'b1, 8'h00, 8'h01, 8'h00, 1'b1},  // 10 R7
      {1'b0, 8'h00, 8'hFF, 8'h00, 1'b0},  // 11 R7 all disabled
      {1'b1, 8'h20, 8'h00, 8'h00, 1'b0},  // 12 R4
      {1'b0, 8'h00, 8'h20, 8'h00, 1'b0},  // 13 R4
      {1'b1, 8'hFF, 8'h00, 8'h00, 1'b0},  // 14
      {1'b0, 8'h00, 8'hFF, 8'hDF, 1'b0},  // 15 R2 R4
      {1'b0, 8'h00, 8'h00, 8'hDF, 1'b1}   // 16 R9 R10
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_pulse = '0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] status_rd;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_src_gate dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_pulse (src_pulse),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .status_rd (status_rd),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [7:0] wd, input logic [7:0] p);
      cfg_we    = we;
      cfg_wdata = wd;
      src_pulse = p;
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
      src_pulse = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status in reset", status_rd, 8'h00);
      chk("R1 irq in reset", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, 8'h00, 8'hFF);
      chk("R1 enables zero after reset", status_rd, 8'h00);

      for (int k = 0; k < NV; k++) begin
         step(TBL[k][25], TBL[k][24:17], TBL[k][16:9]);
         chk($sformatf("R2-table step %0d status", k), status_rd, TBL[k][8:1]);
         chk($sformatf("R10 table step %0d irq", k), {7'b0, irq}, {7'b0, TBL[k][0]});
      end

      // R1: reset in the middle of activity
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 status after mid reset", status_rd, 8'h00);
      chk("R1 irq after mid reset", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, 8'h00, 8'h01);
      chk("R1 pulse ignored after reset", status_rd, 8'h00);

      // R10: irq fall timing
      step(1'b1, 8'hFF, 8'h00);
      step(1'b0, 8'h00, 8'h04);
      chk("R2 bit2 set", status_rd, 8'h04);
      chk("R10 irq not yet high", {7'b0, irq}, 8'h00);
      step(1'b1, 8'h00, 8'h00);
      chk("R7 cleared", status_rd, 8'h00);
      chk("R10 irq still high one cycle", {7'b0, irq}, 8'h01);
      step(1'b0, 8'h00, 8'h00);
      chk("R10 irq fallen", {7'b0, irq}, 8'h00);

      // R6: repeated ack and re-arm on one bit
      step(1'b1, 8'h08, 8'h00);
      step(1'b0, 8'h00, 8'h08);
      step(1'b1, 8'h00, 8'h00);
      step(1'b1, 8'h08, 8'h00);
      step(1'b0, 8'h00, 8'h08);
      chk("R6 re-armed bit3", status_rd, 8'h08);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule